// File: doc/BRIEF.md
# Interrupt Priority Mask with Nesting Stack

This block holds the priority level that the processor is currently serving and decides whether the best pending request may interrupt it. A request reaches the processor only when its priority is strictly above that level. When the processor takes an interrupt, the block saves the old level on a small hardware stack and raises the level to the priority of the request it just took. When the handler signals end-of-interrupt, the block restores the saved level. This lets handlers nest without any software bookkeeping.

Software can also write the level directly. This raises or lowers the mask around a shared resource (a priority ceiling) and does not touch the stack. A mode input picks where the acknowledge comes from. In the software handshake it is a read of the acknowledge register. In the hardware handshake it is a dedicated acknowledge pin from the processor. The priority comparison over the peripheral sources and the vector lookup are done outside the block.

Top module: `irq_prio_mask`

## Requirements
- R1: During and right after reset the level is 15, `irq_o` is 0, `err_o` is 0 and the stack is empty.
- R2: `irq_o` is registered. After a clock edge it is 1 exactly when `pend_valid_i` was 1 at that edge and `pend_prio_i` is greater than the level as updated at that edge. An equal or lower priority never interrupts.
- R3: An acknowledge pushes the current level onto the stack and loads `pend_prio_i` into the level.
- R4: With `hw_mode_i`=0, an acknowledge is a read (`reg_rd_i`) at offset 0x10 and `hw_ack_i` has no effect. With `hw_mode_i`=1, an acknowledge is `hw_ack_i`=1 and a read at 0x10 has no effect.
- R5: A write (`reg_wr_i`) at offset 0x18 is end-of-interrupt. It pops the top stack entry into the level.
- R6: A write at offset 0x08 loads `reg_wdata_i[3:0]` into the level and leaves the stack unchanged.
- R7: A read at 0x08 returns the level in bits [3:0] and zero in bits [31:4]. A read at 0x10 returns `pend_prio_i` in bits [3:0] and zero above. Both return data in the same cycle.
- R8: The stack holds 15 entries. A push onto a full stack is dropped and sets `err_o`, while the level still takes the new priority. A pop from an empty stack leaves the level unchanged and sets `err_o`. `err_o` stays 1 until reset.
- R9: When an acknowledge and an end-of-interrupt fall in the same cycle, the pop is applied first and the push second.
- R10: When a write at 0x08 falls in the same cycle as an acknowledge, the write is dropped.
- R11: `irq_o` is 0 in the cycle after an acknowledge whose priority becomes the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_valid_i | input | 1 | A request is pending |
| pend_prio_i | input | 4 | Priority of the best pending request |
| hw_mode_i | input | 1 | 0: software acknowledge, 1: hardware acknowledge |
| hw_ack_i | input | 1 | Acknowledge pin from the processor |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request to the processor |
| err_o | output | 1 | Sticky stack overflow or underflow flag |

## Verification
A corrupted level shows up at once. The next read at 0x08 returns the wrong value, and `irq_o` fires or stays quiet wrongly for some pending priority on the very next edge. A wrong stack entry or pointer stays hidden until the end-of-interrupt that pops it. For that reason, every chain of acknowledges is unwound back to the bottom, checking the level after each pop. The exhaustive sweep of all level and pending-priority pairs exposes any off-by-one in the comparison within one cycle.

// File: rtl/irq_prio_pkg.sv
`timescale 1ns/1ps
package irq_prio_pkg;
    localparam int PRIO_W = 4;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    localparam prio_t PRIO_RESET = '1;
    localparam addr_t OFS_LEVEL  = 8'h08;
    localparam addr_t OFS_ACK    = 8'h10;
    localparam addr_t OFS_EOI    = 8'h18;

    // Decoded per-cycle events
    typedef struct packed {
        logic  ack;
        logic  eoi;
        logic  wr_level;
        prio_t wlevel;
    } evt_t;

    function automatic logic beats_mask(logic valid, prio_t pend, prio_t mask);
        return valid && (pend > mask);
    endfunction

    function automatic data_t widen(prio_t p);
        return {{(DATA_W-PRIO_W){1'b0}}, p};
    endfunction
endpackage

// File: rtl/irq_prio_decode.sv
`timescale 1ns/1ps
module irq_prio_decode
    import irq_prio_pkg::*;
(
    input  logic  hw_mode_i,
    input  logic  hw_ack_i,
    input  logic  reg_rd_i,
    input  logic  reg_wr_i,
    input  addr_t reg_addr_i,
    input  data_t reg_wdata_i,
    output evt_t  evt_o
);
    logic sw_ack;
    logic wr_lvl_raw;

    always_comb begin
        sw_ack      = reg_rd_i && (reg_addr_i == OFS_ACK);
        wr_lvl_raw  = reg_wr_i && (reg_addr_i == OFS_LEVEL);
        evt_o.ack   = hw_mode_i ? hw_ack_i : sw_ack;
        evt_o.eoi   = reg_wr_i && (reg_addr_i == OFS_EOI);
        // acknowledge has priority over a direct level write
        evt_o.wr_level = wr_lvl_raw && !evt_o.ack;
        evt_o.wlevel   = reg_wdata_i[PRIO_W-1:0];
    end
endmodule

// File: rtl/irq_prio_lifo.sv
`timescale 1ns/1ps
module irq_prio_lifo
    import irq_prio_pkg::*;
#(
    parameter int DEPTH = 15
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  pop_i,
    input  logic  push_i,
    input  prio_t din_i,
    output prio_t top_o,
    output logic  empty_o,
    output logic  ovf_o,
    output logic  unf_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    prio_t            mem [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_after_pop;
    logic             do_pop;
    logic             do_push;

    always_comb begin
        do_pop        = pop_i && (cnt_q != '0);
        cnt_after_pop = cnt_q - CNT_W'(do_pop);
        do_push       = push_i && (cnt_after_pop != CNT_FULL);
        ovf_o         = push_i && !do_push;
        unf_o         = pop_i && (cnt_q == '0);
        empty_o       = (cnt_q == '0);
    end

    always_comb begin
        top_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (cnt_q == CNT_W'(i + 1)) top_o = mem[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_after_pop + CNT_W'(do_push);
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst)
                    mem[g] <= '0;
                else if (do_push && (cnt_after_pop == CNT_W'(g)))
                    mem[g] <= din_i;
            end
        end
    endgenerate
endmodule

// File: rtl/irq_prio_mask.sv
`timescale 1ns/1ps
module irq_prio_mask
    import irq_prio_pkg::*;
#(
    parameter int STACK_DEPTH = 15
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pend_valid_i,
    input  logic [3:0]  pend_prio_i,
    input  logic        hw_mode_i,
    input  logic        hw_ack_i,
    input  logic        reg_rd_i,
    input  logic        reg_wr_i,
    input  logic [7:0]  reg_addr_i,
    input  logic [31:0] reg_wdata_i,
    output logic [31:0] reg_rdata_o,
    output logic        irq_o,
    output logic        err_o
);
    evt_t  evt;
    prio_t prio_q;
    prio_t prio_popped;
    prio_t prio_d;
    prio_t stk_top;
    logic  stk_empty;
    logic  stk_ovf;
    logic  stk_unf;
    logic  irq_q;
    logic  err_q;

    irq_prio_decode u_decode (
        .hw_mode_i   (hw_mode_i),
        .hw_ack_i    (hw_ack_i),
        .reg_rd_i    (reg_rd_i),
        .reg_wr_i    (reg_wr_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .evt_o       (evt)
    );

    // pop is applied before push; push data is the level after the pop
    irq_prio_lifo #(.DEPTH(STACK_DEPTH)) u_lifo (
        .clk     (clk),
        .rst     (rst),
        .pop_i   (evt.eoi),
        .push_i  (evt.ack),
        .din_i   (prio_popped),
        .top_o   (stk_top),
        .empty_o (stk_empty),
        .ovf_o   (stk_ovf),
        .unf_o   (stk_unf)
    );

    always_comb begin
        prio_popped = (evt.eoi && !stk_empty) ? stk_top : prio_q;
        if (evt.ack)
            prio_d = pend_prio_i;
        else if (evt.wr_level)
            prio_d = evt.wlevel;
        else
            prio_d = prio_popped;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prio_q <= PRIO_RESET;
            irq_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            prio_q <= prio_d;
            irq_q  <= beats_mask(pend_valid_i, pend_prio_i, prio_d);
            err_q  <= err_q | stk_ovf | stk_unf;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        if (reg_rd_i) begin
            case (reg_addr_i)
                OFS_LEVEL: reg_rdata_o = widen(prio_q);
                OFS_ACK:   reg_rdata_o = widen(pend_prio_i);
                default:   reg_rdata_o = '0;
            endcase
        end
    end

    assign irq_o = irq_q;
    assign err_o = err_q;
endmodule

// File: rtl/irq_prio_mask_chk.sv
`timescale 1ns/1ps
module irq_prio_mask_chk
    import irq_prio_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        pend_valid_i,
    input logic [3:0]  pend_prio_i,
    input logic        hw_mode_i,
    input logic        hw_ack_i,
    input logic        reg_rd_i,
    input logic        reg_wr_i,
    input logic [7:0]  reg_addr_i,
    input logic [31:0] reg_wdata_i,
    input logic [31:0] reg_rdata_o,
    input logic        irq_o,
    input logic        err_o,
    input logic [3:0]  prio_q
);
    logic ack_ev;
    logic eoi_ev;
    logic wr_lvl;

    always_comb begin
        ack_ev = hw_mode_i ? hw_ack_i : (reg_rd_i && reg_addr_i == OFS_ACK);
        eoi_ev = reg_wr_i && reg_addr_i == OFS_EOI;
        wr_lvl = reg_wr_i && reg_addr_i == OFS_LEVEL;
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (prio_q == 4'hF) && !irq_o && !err_o);

    p_irq_above_mask_r2: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !$past(rst)) |-> $past(pend_valid_i) && ($past(pend_prio_i) > prio_q));

    p_ack_loads_r3: assert property (@(posedge clk) disable iff (rst)
        ack_ev |=> prio_q == $past(pend_prio_i));

    p_hwack_ignored_sw_r4: assert property (@(posedge clk) disable iff (rst)
        (!hw_mode_i && hw_ack_i && !reg_rd_i && !reg_wr_i) |=> $stable(prio_q));

    p_level_write_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_lvl && !ack_ev) |=> prio_q == $past(reg_wdata_i[3:0]));

    p_rdata_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
        reg_rd_i |-> $countones(reg_rdata_o[31:4]) == 0);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    p_write_dropped_r10: assert property (@(posedge clk) disable iff (rst)
        (ack_ev && wr_lvl) |=> prio_q == $past(pend_prio_i));

    p_irq_drops_r11: assert property (@(posedge clk) disable iff (rst)
        ack_ev |=> !irq_o);
endmodule

bind irq_prio_mask irq_prio_mask_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .pend_valid_i (pend_valid_i),
    .pend_prio_i  (pend_prio_i),
    .hw_mode_i    (hw_mode_i),
    .hw_ack_i     (hw_ack_i),
    .reg_rd_i     (reg_rd_i),
    .reg_wr_i     (reg_wr_i),
    .reg_addr_i   (reg_addr_i),
    .reg_wdata_i  (reg_wdata_i),
    .reg_rdata_o  (reg_rdata_o),
    .irq_o        (irq_o),
    .err_o        (err_o),
    .prio_q       (prio_q)
);

// File: tb/irq_prio_mask_bench.sv
`timescale 1ns/1ps
module irq_prio_mask_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pend_valid_i = 1'b0;
    logic [3:0]  pend_prio_i = '0;
    logic        hw_mode_i = 1'b0;
    logic        hw_ack_i = 1'b0;
    logic        reg_rd_i = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic [7:0]  reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        irq_o;
    logic        err_o;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    logic [3:0] m_prio;
    logic [3:0] m_stk [15];
    int         m_sp;
    bit         m_err;
    bit         m_irq;

    always #2 clk = ~clk;

    irq_prio_mask u_irq_prio_mask (
        .clk          (clk),
        .rst          (rst),
        .pend_valid_i (pend_valid_i),
        .pend_prio_i  (pend_prio_i),
        .hw_mode_i    (hw_mode_i),
        .hw_ack_i     (hw_ack_i),
        .reg_rd_i     (reg_rd_i),
        .reg_wr_i     (reg_wr_i),
        .reg_addr_i   (reg_addr_i),
        .reg_wdata_i  (reg_wdata_i),
        .reg_rdata_o  (reg_rdata_o),
        .irq_o        (irq_o),
        .err_o        (err_o)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_state(string tag);
        reg_rd_i   = 1'b1;
        reg_addr_i = 8'h08;
        #0.5;
        chk({tag, " level"}, reg_rdata_o, {28'b0, m_prio});
        chk({tag, " irq"}, {31'b0, irq_o}, {31'b0, m_irq});
        chk({tag, " err"}, {31'b0, err_o}, {31'b0, m_err});
        reg_rd_i = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        pend_valid_i = 1'b0;
        pend_prio_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_prio = 4'hF;
        m_sp = 0;
        m_err = 0;
        m_irq = 0;
    endtask

    task automatic step(bit hwm, bit hwack, bit rd, bit wr, logic [7:0] addr,
                        logic [31:0] wd, bit pv, logic [3:0] pp, string tag);
        bit ack, eoi, wrl;
        @(negedge clk);
        hw_mode_i = hwm;  hw_ack_i = hwack;
        reg_rd_i = rd;    reg_wr_i = wr;
        reg_addr_i = addr; reg_wdata_i = wd;
        pend_valid_i = pv; pend_prio_i = pp;
        #0.5;
        if (rd && addr == 8'h10) chk("R7 ack read", reg_rdata_o, {28'b0, pp});
        @(posedge clk);
        #1;
        ack = hwm ? hwack : (rd && addr == 8'h10);
        eoi = wr && addr == 8'h18;
        wrl = wr && addr == 8'h08;
        if (eoi) begin
            if (m_sp == 0) m_err = 1;
            else begin m_sp--; m_prio = m_stk[m_sp]; end
        end
        if (ack) begin
            if (m_sp == 15) m_err = 1;
            else begin m_stk[m_sp] = m_prio; m_sp++; end
            m_prio = pp;
        end else if (wrl) begin
            m_prio = wd[3:0];
        end
        m_irq = pv && (pp > m_prio);
        hw_ack_i = 1'b0;
        reg_rd_i = 1'b0;
        reg_wr_i = 1'b0;
        check_state(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state, top priority pending is still masked
        do_reset();
        pend_valid_i = 1'b1;
        pend_prio_i = 4'hF;
        check_state("R1 reset");
        step(0, 0, 0, 0, 8'h00, 0, 1, 4'hF, "R1 idle at 15");

        // R8: pop on empty stack
        step(0, 0, 0, 1, 8'h18, 0, 0, 0, "R8 underflow");
        do_reset();

        // R2/R6: every level against every pending priority
        for (int m = 0; m < 16; m++) begin
            for (int p = 0; p < 16; p++) begin
                step(0, 0, 0, 1, 8'h08, 32'hFFFF_FFF0 | m, 1, 4'(p), "R2 R6 sweep");
            end
            step(0, 0, 0, 0, 8'h00, 0, 0, 4'hF, "R2 no valid");
        end
        // R7: read at level offset has zero upper bits (checked in check_state)
        step(0, 0, 1, 0, 8'h08, 0, 0, 0, "R7 level read");

        // R3/R4/R11/R8: software acknowledge chain to overflow
        step(0, 0, 0, 1, 8'h08, 0, 1, 0, "R6 level 0");
        for (int i = 1; i <= 15; i++) begin
            step(0, 0, 0, 0, 8'h00, 0, 1, 4'(i), "R2 pending above");
            step(0, 0, 1, 0, 8'h10, 0, 1, 4'(i), "R3 R11 sw ack");
            step(0, 1, 0, 0, 8'h00, 0, 1, 4'hF, "R4 hw pin ignored in sw mode");
        end
        step(0, 0, 1, 0, 8'h10, 0, 0, 4'h9, "R8 overflow");
        // R5: unwind the full stack
        for (int i = 0; i < 15; i++) begin
            step(0, 0, 0, 1, 8'h18, 0, 0, 0, "R5 eoi pop");
        end

        // hardware mode
        do_reset();
        step(1, 0, 0, 1, 8'h08, 1, 0, 0, "R6 hw level 1");
        step(1, 0, 1, 0, 8'h10, 0, 1, 4'h7, "R4 sw read ignored in hw mode");
        step(1, 1, 0, 0, 8'h00, 0, 1, 4'h3, "R3 hw ack");
        step(1, 0, 0, 1, 8'h08, 2, 0, 0, "R6 write keeps stack");
        step(1, 1, 0, 0, 8'h00, 0, 1, 4'h6, "R3 hw ack 2");
        step(1, 1, 0, 1, 8'h18, 0, 1, 4'h8, "R9 ack with eoi");
        step(1, 1, 0, 1, 8'h08, 5, 1, 4'h7, "R10 write dropped");
        step(1, 0, 0, 1, 8'h18, 0, 0, 0, "R5 hw pop 1");
        step(1, 0, 0, 1, 8'h18, 0, 0, 0, "R5 hw pop 2");
        step(1, 0, 0, 1, 8'h18, 0, 0, 0, "R5 hw pop 3");
        step(1, 1, 0, 1, 8'h18, 0, 1, 4'hC, "R9 ack with eoi on empty");
        step(1, 0, 0, 1, 8'h18, 0, 1, 4'hD, "R9 R8 pop after");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule